// File: doc/BRIEF.md
# Escalating Watchdog with Repeat-Overflow Memory

This block is a watchdog timer that escalates in stages. While software services it in time, it counts down quietly. When the count runs out it enters a prewarning stage, pulses an interrupt and starts a short second countdown. If that countdown also expires, the block asks for a user reset. It also records, in a sticky flag, that the watchdog has already been exceeded once.

The flag survives user resets. Only a power reset clears it, or a clear strobe that arrives while the block is in prewarning; a strobe at any other time does nothing. If the prewarning countdown expires while the flag is still set, the block raises a permanent reset output instead of a plain reset request. That output holds until power reset. Software that lets the watchdog expire once on purpose, for example during a self test, clears the flag from its prewarning interrupt handler so that a later real failure yields a single reset rather than a lock-up.

States: `WS_RUN` (normal countdown), `WS_PREWARN` (prewarning countdown), `WS_RST_REQ` (reset requested), `WS_LOCKED` (permanent reset). Transitions:
- RUN→PREWARN on overflow.
- PREWARN→RST_REQ on expiry with the flag clear, or with the flag cleared in that same cycle.
- PREWARN→LOCKED on expiry with the flag set.
- PREWARN→RUN and RST_REQ→RUN on user reset.
- Any state→RUN on power reset.

Top module: `wdg_escalator`

## Requirements
- R1: While `por_n` is low, `prewarn_irq`, `reset_req`, `perm_reset` and `once_flag` are 0. The block leaves power reset in the normal state with the counter at `NORM_LOAD`.
- R2: In the normal state, a `kick` or `usr_rst` sampled at an edge reloads the counter to `NORM_LOAD`. Without service, the overflow is taken at the edge `NORM_LOAD`+1 edges after the last reload. A `kick` sampled at that same edge wins, and no overflow occurs.
- R3: On overflow the block enters prewarning and reloads `PRE_LOAD`. `prewarn_irq` is high for exactly the one cycle after the entry edge.
- R4: `kick` has no effect in prewarning. Expiry is taken `PRE_LOAD`+1 edges after the entry edge.
- R5: Expiry with the flag clear sets `reset_req` and sets `once_flag` at that edge. `reset_req` stays high until a `usr_rst` is sampled.
- R6: A `usr_rst` returns the block from normal, prewarning or reset-requested to normal with a `NORM_LOAD` reload. It leaves `once_flag` unchanged.
- R7: A `clr_wr` strobe clears `once_flag` at the next edge only if it is sampled in prewarning. Outside prewarning it has no effect.
- R8: Expiry with `once_flag` set raises `perm_reset` (with `reset_req` low). `perm_reset` stays high until power reset; `usr_rst` and `kick` are ignored in that state.
- R9: If `clr_wr` is sampled at the expiry edge, the clear is honoured first. The result is a plain `reset_req` rather than `perm_reset`, and `once_flag` is set again.
- R10: A power reset clears `once_flag` and `perm_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, asynchronous, active low |
| usr_rst | input | 1 | User reset event, synchronous, active high |
| kick | input | 1 | Service strobe |
| clr_wr | input | 1 | Clear strobe for the repeat flag |
| prewarn_irq | output | 1 | One-cycle pulse on entry to prewarning |
| reset_req | output | 1 | Reset request, held until user reset |
| perm_reset | output | 1 | Permanent reset, held until power reset |
| once_flag | output | 1 | Sticky "already exceeded once" flag |

## Verification
Two pairs of functions can coincide. A service strobe can land on the very edge at which the normal count overflows. A flag-clear strobe can land on the very edge at which the prewarning count expires while the flag is set. The bench times each strobe to the computed edge. For the first pair it expects no interrupt until a full reload period later. For the second it expects a plain reset request rather than a permanent reset, with the flag set again afterwards. The expected event stamps are queued by the driver and compared by a monitor against the observed events.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WS_RUN      = 2'd0,
        WS_PREWARN  = 2'd1,
        WS_RST_REQ  = 2'd2,
        WS_LOCKED   = 2'd3
    } wdg_state_e;

    typedef struct packed {
        logic load_norm;
        logic load_pre;
        logic dec;
    } cnt_cmd_t;

endpackage

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int NORM_LOAD = 1000,
    parameter int PRE_LOAD  = 200,
    parameter int CW        = 10
) (
    input  logic     clk,
    input  logic     por_n,
    input  cnt_cmd_t cmd,
    output logic     zero
);

    localparam logic [CW-1:0] NORM_V = CW'(NORM_LOAD);
    localparam logic [CW-1:0] PRE_V  = CW'(PRE_LOAD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= NORM_V;
        end else if (cmd.load_norm) begin
            cnt_q <= NORM_V;
        end else if (cmd.load_pre) begin
            cnt_q <= PRE_V;
        end else if (cmd.dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_CNT_ONE_CMD: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({cmd.load_norm, cmd.load_pre, cmd.dec})); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!por_n)
        (zero && cmd.dec) |-> 1'b0); // R4

endmodule

// File: rtl/wdg_once_flag.sv
module wdg_once_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set_evt,
    input  logic clr_ok,
    input  logic usr_rst,
    output logic flag
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_ok) begin
            flag <= 1'b0;
        end
    end

    AST_FLAG_CLEAR_GATED: assert property (@(posedge clk) disable iff (!por_n)
        $fell(flag) |-> $past(clr_ok)); // R7

    AST_FLAG_KEEP_USR: assert property (@(posedge clk) disable iff (!por_n)
        (flag && usr_rst && !clr_ok) |=> flag); // R6

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     kick,
    input  logic     usr_rst,
    input  logic     clr_wr,
    input  logic     zero,
    input  logic     flag,
    output cnt_cmd_t cmd,
    output logic     set_flag,
    output logic     clr_ok,
    output logic     irq,
    output logic     rst_req,
    output logic     perm
);

    wdg_state_e state_q, nxt;

    always_comb begin
        nxt      = state_q;
        cmd      = '0;
        set_flag = 1'b0;
        unique case (state_q)
            WS_RUN: begin
                if (usr_rst || kick) begin
                    cmd.load_norm = 1'b1;
                end else if (zero) begin
                    nxt          = WS_PREWARN;
                    cmd.load_pre = 1'b1;
                end else begin
                    cmd.dec = 1'b1;
                end
            end
            WS_PREWARN: begin
                if (usr_rst) begin
                    nxt           = WS_RUN;
                    cmd.load_norm = 1'b1;
                end else if (zero) begin
                    set_flag = 1'b1;
                    nxt      = (flag && !clr_wr) ? WS_LOCKED : WS_RST_REQ;
                end else begin
                    cmd.dec = 1'b1;
                end
            end
            WS_RST_REQ: begin
                if (usr_rst) begin
                    nxt           = WS_RUN;
                    cmd.load_norm = 1'b1;
                end
            end
            WS_LOCKED: begin
                nxt = WS_LOCKED;
            end
            default: begin
                nxt = WS_LOCKED;
            end
        endcase
    end

    assign clr_ok = (state_q == WS_PREWARN) && clr_wr;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= WS_RUN;
        end else begin
            state_q <= nxt;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
            perm    <= 1'b0;
        end else begin
            irq     <= (nxt == WS_PREWARN) && (state_q != WS_PREWARN);
            rst_req <= (nxt == WS_RST_REQ);
            perm    <= (nxt == WS_LOCKED);
        end
    end

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        perm |=> perm); // R8

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_req) |-> $past(usr_rst)); // R5

    AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq) |-> ($past(state_q) == WS_RUN)); // R3

endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator
    import wdg_pkg::*;
#(
    parameter int NORM_LOAD = 1000,
    parameter int PRE_LOAD  = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic usr_rst,
    input  logic kick,
    input  logic clr_wr,
    output logic prewarn_irq,
    output logic reset_req,
    output logic perm_reset,
    output logic once_flag
);

    localparam int MAX_LOAD = (NORM_LOAD > PRE_LOAD) ? NORM_LOAD : PRE_LOAD;
    localparam int CW       = $clog2(MAX_LOAD + 1);

    cnt_cmd_t cmd;
    logic     zero;
    logic     set_flag;
    logic     clr_ok;

    wdg_counter #(
        .NORM_LOAD (NORM_LOAD),
        .PRE_LOAD  (PRE_LOAD),
        .CW        (CW)
    ) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .cmd   (cmd),
        .zero  (zero)
    );

    wdg_once_flag u_flag (
        .clk     (clk),
        .por_n   (por_n),
        .set_evt (set_flag),
        .clr_ok  (clr_ok),
        .usr_rst (usr_rst),
        .flag    (once_flag)
    );

    wdg_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .kick     (kick),
        .usr_rst  (usr_rst),
        .clr_wr   (clr_wr),
        .zero     (zero),
        .flag     (once_flag),
        .cmd      (cmd),
        .set_flag (set_flag),
        .clr_ok   (clr_ok),
        .irq      (prewarn_irq),
        .rst_req  (reset_req),
        .perm     (perm_reset)
    );

    AST_PERM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(perm_reset) |-> $past(once_flag)); // R8

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        prewarn_irq |=> !prewarn_irq); // R3

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
        !(reset_req && perm_reset)); // R8

endmodule

// File: tb/wdg_escalator_test.sv
module wdg_escalator_test;

    localparam int CLK_PERIOD = 10;
    localparam int L = 20;
    localparam int P = 8;

    localparam int EV_IRQ  = 1;
    localparam int EV_RRQ  = 2;
    localparam int EV_PERM = 3;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic usr_rst = 1'b0;
    logic kick = 1'b0;
    logic clr_wr = 1'b0;
    logic prewarn_irq, reset_req, perm_reset, once_flag;

    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic rr_prev = 1'b0;
    logic pm_prev = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdg_escalator #(.NORM_LOAD(L), .PRE_LOAD(P)) uut (
        .clk         (clk),
        .por_n       (por_n),
        .usr_rst     (usr_rst),
        .kick        (kick),
        .clr_wr      (clr_wr),
        .prewarn_irq (prewarn_irq),
        .reset_req   (reset_req),
        .perm_reset  (perm_reset),
        .once_flag   (once_flag)
    );

    always @(posedge clk) begin
        if (!por_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cyc %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic push(int kind, int at, string req);
        exp_t e;
        e.kind = kind;
        e.cyc  = at;
        e.req  = req;
        expq.push_back(e);
    endtask

    // monitor: stamps observed events and compares against the queue
    always @(negedge clk) begin
        if (!por_n) begin
            rr_prev <= 1'b0;
            pm_prev <= 1'b0;
        end else begin
            int kind;
            kind = 0;
            if (prewarn_irq)                 kind = EV_IRQ;
            else if (reset_req && !rr_prev)  kind = EV_RRQ;
            else if (perm_reset && !pm_prev) kind = EV_PERM;
            if (kind != 0) begin
                n_vec++;
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected event: actual kind %0d at cyc %0d, expected none", kind, cyc);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.kind != kind || e.cyc != cyc) begin
                        n_bad++;
                        $display("FAIL %s event: actual kind %0d at cyc %0d, expected kind %0d at cyc %0d",
                                 e.req, kind, cyc, e.kind, e.cyc);
                    end
                end
            end
            rr_prev <= reset_req;
            pm_prev <= perm_reset;
        end
    end

    task automatic at_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_kick(int c);
        at_cyc(c); kick = 1'b1; @(negedge clk); kick = 1'b0;
    endtask

    task automatic do_usr(int c);
        at_cyc(c); usr_rst = 1'b1; @(negedge clk); usr_rst = 1'b0;
    endtask

    task automatic do_clr(int c);
        at_cyc(c); clr_wr = 1'b1; @(negedge clk); clr_wr = 1'b0;
    endtask

    task automatic power_reset();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 irq", prewarn_irq, 0);
        chk("R1 req", reset_req, 0);
        chk("R1 perm", perm_reset, 0);
        chk("R1 flag", once_flag, 0);
        por_n = 1'b1;

        // R2: service keeps it alive; kick on the overflow edge wins
        do_kick(5);                       // reload at 6
        do_kick(15);                      // reload at 16
        do_kick(36);                      // lands on overflow edge 37
        push(EV_IRQ, 37 + L + 1, "R2/R3");
        push(EV_RRQ, 37 + L + P + 2, "R4/R5");
        do_kick(60);                      // R4: ignored in prewarning
        at_cyc(68);
        chk("R5 flag set", once_flag, 1);
        at_cyc(75);
        chk("R5 req held", reset_req, 1);

        // R6: user reset keeps flag
        do_usr(80);                       // sampled 81
        at_cyc(82);
        chk("R6 req released", reset_req, 0);
        chk("R6 flag kept", once_flag, 1);
        push(EV_IRQ, 81 + L + 1, "R6");
        push(EV_RRQ, 81 + L + P + 2, "R7");
        do_clr(90);                       // R7: normal state, ignored
        at_cyc(92);
        chk("R7 clear ignored", once_flag, 1);
        do_clr(104);                      // R7: in prewarning, accepted
        at_cyc(106);
        chk("R7 clear accepted", once_flag, 0);
        at_cyc(113);
        chk("R7 flag reset", once_flag, 1);

        // R8: second expiry with flag set locks
        do_usr(120);                      // sampled 121
        push(EV_IRQ, 121 + L + 1, "R8");
        push(EV_PERM, 121 + L + P + 2, "R8");
        at_cyc(153);
        chk("R8 perm", perm_reset, 1);
        chk("R8 req low", reset_req, 0);
        do_usr(155);
        do_kick(157);
        at_cyc(160);
        chk("R8 perm after usr", perm_reset, 1);

        // R10: power reset clears
        power_reset();
        chk("R10 perm", perm_reset, 0);
        chk("R10 flag", once_flag, 0);
        por_n = 1'b1;

        // R9: clear coincides with expiry while flag set
        push(EV_IRQ, L + 1, "R9");
        push(EV_RRQ, L + P + 2, "R9");
        do_usr(35);                       // sampled 36
        push(EV_IRQ, 36 + L + 1, "R9");
        push(EV_RRQ, 36 + L + P + 2, "R9");
        do_clr(36 + L + P + 1);           // sampled at the expiry edge
        at_cyc(68);
        chk("R9 flag again", once_flag, 1);
        chk("R9 no perm", perm_reset, 0);
        at_cyc(75);
        chk("R9 queue drained", expq.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule